// File: doc/BRIEF.md
# Word-Aligned Instruction Fetch Unit

This unit holds the program counter of a 32-bit processor whose instructions are all four bytes long and aligned to four bytes. The two low address bits can never be anything but zero, so the unit keeps only the word index, which is the upper 30 bits. On every clock it drives the instruction memory with the byte address of the current instruction. It also gives the datapath the byte address of the next sequential instruction.

On each enabled clock edge the unit loads one of two values. The first is the sequential successor, which is word index plus one. The second is a branch target, which is word index plus one plus the sign-extended 16-bit displacement from the current instruction. The target is taken only when the control logic requests a branch and the datapath reports that the two compared registers are equal. When fetch enable is low the counter stays where it is.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the word index becomes 0, so `imem_addr` reads 0x00000000 after that edge.
- R2: Bits [1:0] of `imem_addr` are always 0, and bits [31:2] carry the stored word index.
- R3: On an edge where `fetch_en` is high and no branch is taken, the word index grows by 1, so `imem_addr` grows by 4.
- R4: On an edge where `fetch_en`, `br_req` and `eq_flag` are all high, the word index becomes old index + 1 + the sign extension of `br_disp`, where `br_disp` is treated as a two's-complement count of words. Negative displacements move backwards.
- R5: A branch is taken only when `br_req` and `eq_flag` are both high. If only one of them is high, the edge behaves as in R3.
- R6: On an edge where `fetch_en` is low, the word index keeps its value, and `br_req`, `eq_flag` and `br_disp` have no effect.
- R7: All next-address arithmetic wraps modulo 2^30 on the word index, and no overflow is flagged. For example, index 0x3FFFFFFF plus 1 gives 0.
- R8: `seq_addr` always equals ((word index + 1) mod 2^30) with two zero bits appended below it.
- R9: Reset takes priority over `fetch_en` and over a taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Allows the PC to advance on this edge |
| br_req | input | 1 | Branch request from control decode |
| eq_flag | input | 1 | Equality result of the two source registers |
| br_disp | input | 16 | Signed word displacement from the current instruction |
| imem_addr | output | 32 | Byte address of the current instruction |
| seq_addr | output | 32 | Byte address of the next sequential instruction |

## Verification
The wrap-around corner is the hardest state to reach. Counting up to word index 0x3FFFFFFF one step at a time is impossible in a bench. The stimulus gets there with a taken branch of displacement -2 from index 0, which lands on the top index in one step. A sequential step and a second backward branch then cross the boundary in both directions. A reset asserted together with a taken branch, and a stall during which the branch inputs toggle, cover the two priority orderings.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  // Selected source for the next word index
  typedef enum logic [1:0] {
    NXT_HOLD   = 2'd0,
    NXT_SEQ    = 2'd1,
    NXT_BRANCH = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
  parameter int PC_W = 30,
  parameter logic [PC_W-1:0] RESET_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= RESET_WORD;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/ifu_next_addr.sv
module ifu_next_addr
  import ifu_pkg::*;
#(
  parameter int PC_W   = 30,
  parameter int DISP_W = 16
) (
  input  logic              [PC_W-1:0]   cur_word,
  input  logic              [DISP_W-1:0] disp,
  input  logic                           fetch_en,
  input  logic                           br_req,
  input  logic                           eq_flag,
  output nxt_sel_e                       sel,
  output logic              [PC_W-1:0]   seq_word,
  output logic              [PC_W-1:0]   next_word
);
  localparam int EXT_W = PC_W - DISP_W;

  function automatic logic [PC_W-1:0] widen_disp(input logic [DISP_W-1:0] v);
    return {{EXT_W{v[DISP_W-1]}}, v};
  endfunction

  function automatic logic [PC_W-1:0] step_one(input logic [PC_W-1:0] w);
    return w + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

  logic [PC_W-1:0] target_word;

  always_comb begin
    seq_word    = step_one(cur_word);
    target_word = seq_word + widen_disp(disp);
    if (!fetch_en)              sel = NXT_HOLD;
    else if (br_req && eq_flag) sel = NXT_BRANCH;
    else                        sel = NXT_SEQ;
    unique case (sel)
      NXT_BRANCH: next_word = target_word;
      NXT_SEQ:    next_word = seq_word;
      default:    next_word = cur_word;
    endcase
  end
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int DISP_W     = 16,
  parameter logic [ADDR_W-ALIGN_BITS-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic              br_req,
  input  logic              eq_flag,
  input  logic [DISP_W-1:0] br_disp,
  output logic [ADDR_W-1:0] imem_addr,
  output logic [ADDR_W-1:0] seq_addr
);
  localparam int PC_W = ADDR_W - ALIGN_BITS;

  nxt_sel_e        sel;
  logic [PC_W-1:0] word_q;
  logic [PC_W-1:0] word_seq;
  logic [PC_W-1:0] word_nxt;
  logic            load_en;
  logic            br_taken;

  ifu_next_addr #(.PC_W(PC_W), .DISP_W(DISP_W)) nxt_i (
    .cur_word (word_q),
    .disp     (br_disp),
    .fetch_en (fetch_en),
    .br_req   (br_req),
    .eq_flag  (eq_flag),
    .sel      (sel),
    .seq_word (word_seq),
    .next_word(word_nxt)
  );

  assign load_en  = (sel != NXT_HOLD);
  assign br_taken = (sel == NXT_BRANCH);

  ifu_pc_reg #(.PC_W(PC_W), .RESET_WORD(RESET_WORD)) pc_i (
    .clk    (clk),
    .rst    (rst),
    .load_en(load_en),
    .d      (word_nxt),
    .q      (word_q)
  );

  assign imem_addr = {word_q,   {ALIGN_BITS{1'b0}}};
  assign seq_addr  = {word_seq, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int DISP_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_en,
  input logic              br_req,
  input logic              eq_flag,
  input logic [DISP_W-1:0] br_disp,
  input logic [ADDR_W-1:0] imem_addr,
  input logic [ADDR_W-1:0] seq_addr,
  input logic              br_taken
);
  localparam int PC_W = ADDR_W - ALIGN_BITS;

  logic [PC_W-1:0] w_now;
  logic [PC_W-1:0] w_plus1;
  logic [PC_W-1:0] w_tgt;
  assign w_now   = imem_addr[ADDR_W-1:ALIGN_BITS];
  assign w_plus1 = w_now + PC_W'(1);
  assign w_tgt   = w_plus1 + {{(PC_W-DISP_W){br_disp[DISP_W-1]}}, br_disp};

  // R1 R9
  reset_zero_chk: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R2
  align_chk: assert property (@(posedge clk) disable iff (rst)
    imem_addr[ALIGN_BITS-1:0] == '0);

  // R3 R5 R7
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && !(br_req && eq_flag)) |=> w_now == $past(w_plus1));

  // R4
  branch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && br_req && eq_flag) |=> w_now == $past(w_tgt));

  // R5
  taken_cond_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (fetch_en && br_req && eq_flag));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> $stable(imem_addr));

  // R8
  seq_addr_chk: assert property (@(posedge clk) disable iff (rst)
    seq_addr == {w_plus1, {ALIGN_BITS{1'b0}}});
endmodule

bind ifu_fetch_unit ifu_fetch_chk #(
  .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .DISP_W(DISP_W)
) chk_i (
  .clk(clk), .rst(rst), .fetch_en(fetch_en), .br_req(br_req),
  .eq_flag(eq_flag), .br_disp(br_disp), .imem_addr(imem_addr),
  .seq_addr(seq_addr), .br_taken(br_taken)
);

// File: tb/ifu_fetch_unit_tb_top.sv
module ifu_fetch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_en;
  logic        br_req;
  logic        eq_flag;
  logic [15:0] br_disp;
  logic [31:0] imem_addr;
  logic [31:0] seq_addr;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  longint ref_word;                        // behavioural word index
  localparam longint MASK = (64'd1 << 30) - 1;

  always #5 clk = ~clk;

  ifu_fetch_unit dut_i (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .br_req(br_req),
    .eq_flag(eq_flag), .br_disp(br_disp),
    .imem_addr(imem_addr), .seq_addr(seq_addr)
  );

  // Reference model: updates on every edge from the inputs held there
  always @(posedge clk) begin
    if (rst) ref_word = 0;
    else if (fetch_en && br_req && eq_flag)
      ref_word = (ref_word + 1 + longint'($signed(br_disp))) & MASK;
    else if (fetch_en)
      ref_word = (ref_word + 1) & MASK;
  end

  task automatic check(input string tag);
    logic [31:0] exp_pc, exp_seq;
    exp_pc  = 32'(ref_word << 2);
    exp_seq = 32'(((ref_word + 1) & MASK) << 2);
    total++;
    if (imem_addr !== exp_pc) begin
      bad++;
      $display("FAIL %s imem_addr act=%h exp=%h", tag, imem_addr, exp_pc);
    end
    total++;
    if (seq_addr !== exp_seq) begin
      bad++;
      $display("FAIL %s seq_addr(R8) act=%h exp=%h", tag, seq_addr, exp_seq);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic en,
                      input logic rq, input logic eq, input logic [15:0] d);
    rst = r; fetch_en = en; br_req = rq; eq_flag = eq; br_disp = d;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    ref_word = 0;
    rst = 1; fetch_en = 1; br_req = 1; eq_flag = 1; br_disp = 16'h0040;
    @(negedge clk);
    step("R1_reset", 1, 1, 1, 1, 16'h0040);
    for (int i = 0; i < 4; i++) step("R3_seq", 0, 1, 0, 0, 16'h1234);
    step("R4_fwd", 0, 1, 1, 1, 16'h0010);
    step("R4_back", 0, 1, 1, 1, 16'hFFF0);
    step("R5_req_only", 0, 1, 1, 0, 16'h0100);
    step("R5_eq_only", 0, 1, 0, 1, 16'h0100);
    for (int i = 0; i < 3; i++) step("R6_stall", 0, 0, i[0], 1, 16'h7FFF);
    step("R2_R3_resume", 0, 1, 0, 0, 16'h0000);
    step("R9_rst_hi", 1, 1, 1, 1, 16'h0020);
    step("R7_wrap_back", 0, 1, 1, 1, 16'hFFFE);
    total++;
    if (imem_addr !== 32'hFFFF_FFFC) begin
      bad++;
      $display("FAIL R7 act=%h exp=fffffffc", imem_addr);
    end
    step("R7_wrap_seq", 0, 1, 0, 0, 16'h0000);
    step("R7_wrap_disp_neg", 0, 1, 1, 1, 16'h8000);
    step("R4_max_fwd", 0, 1, 1, 1, 16'h7FFF);
    for (int i = 0; i < 40; i++)
      step("R4_R5_mix", 0, i % 5 != 0, i[0], i[1], 16'(i * 977));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule